// File: doc/BRIEF.md
# Banked Extended-Precision Accumulator Pair

This block holds two 52-bit multiply-accumulate accumulators. Each one is made of a 4-bit guard extension, a 24-bit high word and a 24-bit low word. A bank-select input chooses which accumulator the 24-bit data bus can see. Reads and writes of the high and low words go only to that accumulator. The selected accumulator is also presented in full on a 52-bit output, which feeds an external adder. The adder's 52-bit result comes back through an accumulate-load strobe.

A narrow (16-bit) mode changes how the words map onto the bus. In this mode a low-word write lands in the upper 16 bits of the low word, and a low-word read returns those 16 bits sign-extended to 24. A high-word write in narrow mode leaves the guard extension alone. In wide mode the same write fills the extension with the sign of the written word. Two transfer strobes copy a whole accumulator to the other one, whatever the bank select is.

Top module: `acc_pair_bank`

## Requirements
- R1: A synchronous reset clears all 52 bits of both accumulators.
- R2: Bus writes and accumulate loads change only the accumulator chosen by `bank_sel` (1 = accumulator 1, 0 = accumulator 0). `rd_hi`, `rd_lo` and `acc_out` show only that accumulator, with `acc_out` = {extension[51:48], high[47:24], low[23:0]}.
- R3: A high-word write loads the high word and forces the low word to zero. In wide mode (`mode16`=0) it also sets all four extension bits to bus bit 23.
- R4: In narrow mode (`mode16`=1) a high-word write leaves the extension bits at their previous value.
- R5: In wide mode a low-word write loads all 24 bus bits into the low word and leaves the high word and the extension unchanged.
- R6: In narrow mode a low-word write places bus bits 15:0 into low-word bits 23:8 and clears low-word bits 7:0. Bus bits 23:16 are ignored, and the high word and the extension are unchanged.
- R7: `rd_lo` returns the whole low word in wide mode. In narrow mode it returns low-word bits 23:8 on bits 15:0, with bits 23:16 all equal to low-word bit 23. `rd_hi` always returns the high word.
- R8: `xfer_0to1` copies all 52 bits of accumulator 0 into accumulator 1, and `xfer_1to0` copies all 52 bits of accumulator 1 into accumulator 0, regardless of `bank_sel`. When both strobes are asserted together, the two accumulators exchange their contents.
- R9: In a cycle where either transfer strobe is set, bus writes and accumulate loads have no effect on either accumulator.
- R10: `acc_load` writes `acc_in` into the selected accumulator in one clock, and it takes priority over a bus write in the same cycle.
- R11: When `wr_hi` and `wr_lo` are asserted together, the result is that of the high-word write alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode16 | input | 1 | 1 = narrow (16-bit) word mapping, 0 = wide (24-bit) |
| bank_sel | input | 1 | Accumulator visible to the bus and the adder |
| wr_hi | input | 1 | Write the high word from `wr_data` |
| wr_lo | input | 1 | Write the low word from `wr_data` |
| wr_data | input | 24 | Bus write data |
| acc_load | input | 1 | Load the adder result into the selected accumulator |
| acc_in | input | 52 | Adder result |
| xfer_0to1 | input | 1 | Copy accumulator 0 into accumulator 1 |
| xfer_1to0 | input | 1 | Copy accumulator 1 into accumulator 0 |
| rd_hi | output | 24 | High word of the selected accumulator |
| rd_lo | output | 24 | Low word of the selected accumulator, mapped by mode |
| acc_out | output | 52 | Full selected accumulator |

## Verification
All outputs are combinational views of the stored words. A corrupted extension, high word or low word therefore shows on `acc_out` in the cycle that follows the faulty update, as soon as `bank_sel` points at that accumulator. A write that leaks into the unselected bank stays hidden until the bank select flips. For that reason the tests read both banks after each operation. A wrong narrow-mode mapping appears only in the low field and on `rd_lo`. The tests compare both in narrow and in wide mode, using positive and negative low words.

// File: rtl/acc_pair_bank.sv
module acc_pair_bank #(
  parameter int EXT_W    = 4,
  parameter int WORD_W   = 24,
  parameter int NARROW_W = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          mode16,
  input  logic                          bank_sel,
  input  logic                          wr_hi,
  input  logic                          wr_lo,
  input  logic [WORD_W-1:0]             wr_data,
  input  logic                          acc_load,
  input  logic [EXT_W+2*WORD_W-1:0]     acc_in,
  input  logic                          xfer_0to1,
  input  logic                          xfer_1to0,
  output logic [WORD_W-1:0]             rd_hi,
  output logic [WORD_W-1:0]             rd_lo,
  output logic [EXT_W+2*WORD_W-1:0]     acc_out
);
  localparam int ACC_W = EXT_W + 2*WORD_W;
  localparam int PAD_W = WORD_W - NARROW_W;
  localparam int HI_LSB = WORD_W;
  localparam int EX_LSB = 2*WORD_W;

  logic [ACC_W-1:0] acc_q [2];
  logic             xfer_any;
  logic             bus_act;
  logic [WORD_W-1:0] lo_sel;

  assign xfer_any = xfer_0to1 | xfer_1to0;
  assign bus_act  = wr_hi | wr_lo | acc_load;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < 2; b++) acc_q[b] <= '0;
    end else if (xfer_any) begin
      if (xfer_0to1) acc_q[1] <= acc_q[0];
      if (xfer_1to0) acc_q[0] <= acc_q[1];
    end else if (acc_load) begin
      acc_q[bank_sel] <= acc_in;
    end else if (wr_hi) begin
      acc_q[bank_sel][HI_LSB +: WORD_W] <= wr_data;
      acc_q[bank_sel][0 +: WORD_W]      <= '0;
      if (!mode16) acc_q[bank_sel][EX_LSB +: EXT_W] <= {EXT_W{wr_data[WORD_W-1]}};
    end else if (wr_lo) begin
      if (mode16) acc_q[bank_sel][0 +: WORD_W] <= {wr_data[NARROW_W-1:0], {PAD_W{1'b0}}};
      else        acc_q[bank_sel][0 +: WORD_W] <= wr_data;
    end
  end

  assign acc_out = acc_q[bank_sel];
  assign lo_sel  = acc_out[0 +: WORD_W];
  assign rd_hi   = acc_out[HI_LSB +: WORD_W];
  assign rd_lo   = mode16 ? {{PAD_W{lo_sel[WORD_W-1]}}, lo_sel[WORD_W-1:PAD_W]} : lo_sel;

  logic [ACC_W-1:0] acc0, acc1;
  assign acc0 = acc_q[0];
  assign acc1 = acc_q[1];

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (acc0 == '0 && acc1 == '0)); // R1
  AST_BANK0_ISOLATED: assert property (@(posedge clk) disable iff (rst)
    (!xfer_any && bus_act && bank_sel) |=> acc0 == $past(acc0)); // R2
  AST_BANK1_ISOLATED: assert property (@(posedge clk) disable iff (rst)
    (!xfer_any && bus_act && !bank_sel) |=> acc1 == $past(acc1)); // R2
  AST_HI_CLEARS_LO: assert property (@(posedge clk) disable iff (rst)
    (!xfer_any && !acc_load && wr_hi && !bank_sel) |=> acc0[WORD_W-1:0] == '0); // R3
  AST_HI_SIGN_FILL: assert property (@(posedge clk) disable iff (rst)
    (!xfer_any && !acc_load && wr_hi && !mode16 && bank_sel) |=>
      acc1[ACC_W-1:EX_LSB] == {EXT_W{$past(wr_data[WORD_W-1])}}); // R3
  AST_HI16_EXT_KEEP: assert property (@(posedge clk) disable iff (rst)
    (!xfer_any && !acc_load && wr_hi && mode16 && !bank_sel) |=>
      acc0[ACC_W-1:EX_LSB] == $past(acc0[ACC_W-1:EX_LSB])); // R4
  AST_LO24_KEEP_UPPER: assert property (@(posedge clk) disable iff (rst)
    (!xfer_any && !acc_load && !wr_hi && wr_lo && !bank_sel) |=>
      acc0[ACC_W-1:HI_LSB] == $past(acc0[ACC_W-1:HI_LSB])); // R5
  AST_LO16_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!xfer_any && !acc_load && !wr_hi && wr_lo && mode16 && bank_sel) |=>
      acc1[PAD_W-1:0] == '0); // R6
  AST_XFER_0TO1: assert property (@(posedge clk) disable iff (rst)
    xfer_0to1 |=> acc1 == $past(acc0)); // R8
  AST_XFER_1TO0: assert property (@(posedge clk) disable iff (rst)
    xfer_1to0 |=> acc0 == $past(acc1)); // R8
  AST_XFER_WINS: assert property (@(posedge clk) disable iff (rst)
    (xfer_0to1 && !xfer_1to0) |=> acc0 == $past(acc0)); // R9
  AST_LOAD_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
    (acc_load && !xfer_any && !bank_sel) |=> acc0 == $past(acc_in)); // R10
endmodule

// File: tb/acc_pair_bank_test.sv
module acc_pair_bank_test;
  logic        clk = 0;
  logic        rst, mode16, bank_sel, wr_hi, wr_lo, acc_load, xfer_0to1, xfer_1to0;
  logic [23:0] wr_data;
  logic [51:0] acc_in;
  logic [23:0] rd_hi, rd_lo;
  logic [51:0] acc_out;
  int total = 0, bad = 0;

  acc_pair_bank uut (.clk(clk), .rst(rst), .mode16(mode16), .bank_sel(bank_sel),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data), .acc_load(acc_load), .acc_in(acc_in),
    .xfer_0to1(xfer_0to1), .xfer_1to0(xfer_1to0), .rd_hi(rd_hi), .rd_lo(rd_lo), .acc_out(acc_out));

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [51:0] got, input logic [51:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic idle();
    wr_hi = 0; wr_lo = 0; acc_load = 0; xfer_0to1 = 0; xfer_1to0 = 0;
  endtask

  task automatic peek(input logic b, output logic [51:0] v);
    bank_sel = b; #1; v = acc_out;
  endtask

  task automatic op(input logic b, input logic m, input logic h, input logic l,
                    input logic [23:0] d, input logic ld, input logic [51:0] ai,
                    input logic x01, input logic x10);
    @(negedge clk);
    bank_sel = b; mode16 = m; wr_hi = h; wr_lo = l; wr_data = d;
    acc_load = ld; acc_in = ai; xfer_0to1 = x01; xfer_1to0 = x10;
    @(negedge clk);
    idle();
  endtask

  task automatic load(input logic b, input logic [51:0] v);
    op(b, 0, 0, 0, 24'h0, 1, v, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; idle();
    @(negedge clk); rst = 0;
  endtask

  task automatic t_reset();
    logic [51:0] v;
    load(0, 52'h1_234567_89ABCD);
    load(1, 52'hE_DCBA98_765432);
    do_reset();
    peek(0, v); chk("R1 bank0 cleared", v, 52'h0);
    peek(1, v); chk("R1 bank1 cleared", v, 52'h0);
  endtask

  task automatic t_hi24();
    logic [51:0] v;
    op(0, 0, 0, 1, 24'h123456, 0, 52'h0, 0, 0);
    op(0, 0, 1, 0, 24'h800001, 0, 52'h0, 0, 0);
    peek(0, v); chk("R3 wide high write negative", v, 52'hF_800001_000000);
    op(0, 0, 1, 0, 24'h7FFFFF, 0, 52'h0, 0, 0);
    peek(0, v); chk("R3 wide high write positive", v, 52'h0_7FFFFF_000000);
    peek(1, v); chk("R2 other bank untouched by high write", v, 52'h0);
  endtask

  task automatic t_lo24();
    logic [51:0] v;
    op(0, 0, 1, 0, 24'h800001, 0, 52'h0, 0, 0);
    op(0, 0, 0, 1, 24'hABCDEF, 0, 52'h0, 0, 0);
    peek(0, v); chk("R5 wide low write keeps high and ext", v, 52'hF_800001_ABCDEF);
    mode16 = 0; #1;
    chk("R7 wide rd_lo", {28'h0, rd_lo}, {28'h0, 24'hABCDEF});
    chk("R7 rd_hi", {28'h0, rd_hi}, {28'h0, 24'h800001});
  endtask

  task automatic t_hi16();
    logic [51:0] v;
    load(1, 52'h5_111111_222222);
    op(1, 1, 1, 0, 24'hFFFF80, 0, 52'h0, 0, 0);
    peek(1, v); chk("R4 narrow high write keeps ext", v, 52'h5_FFFF80_000000);
  endtask

  task automatic t_lo16();
    logic [51:0] v;
    op(1, 1, 0, 1, 24'h12A1B2, 0, 52'h0, 0, 0);
    peek(1, v); chk("R6 narrow low write mapping", v, 52'h5_FFFF80_A1B200);
    mode16 = 1; #1;
    chk("R7 narrow rd_lo negative", {28'h0, rd_lo}, {28'h0, 24'hFFA1B2});
    load(0, 52'h0_000000_3C4DEE);
    bank_sel = 0; mode16 = 1; #1;
    chk("R7 narrow rd_lo positive", {28'h0, rd_lo}, {28'h0, 24'h003C4D});
    mode16 = 0; #1;
    chk("R7 wide rd_lo full word", {28'h0, rd_lo}, {28'h0, 24'h3C4DEE});
  endtask

  task automatic t_xfer();
    logic [51:0] v;
    load(0, 52'hA_AAAAAA_555555);
    load(1, 52'h3_333333_CCCCCC);
    op(1, 0, 0, 0, 24'h0, 0, 52'h0, 1, 0);
    peek(1, v); chk("R8 copy 0 to 1", v, 52'hA_AAAAAA_555555);
    load(0, 52'h6_060606_909090);
    op(0, 0, 0, 0, 24'h0, 0, 52'h0, 1, 1);
    peek(0, v); chk("R8 swap bank0", v, 52'hA_AAAAAA_555555);
    peek(1, v); chk("R8 swap bank1", v, 52'h6_060606_909090);
    op(0, 0, 0, 0, 24'h0, 0, 52'h0, 0, 1);
    peek(0, v); chk("R8 copy 1 to 0", v, 52'h6_060606_909090);
  endtask

  task automatic t_prio();
    logic [51:0] v;
    load(0, 52'h1_010101_020202);
    load(1, 52'h0);
    op(0, 0, 1, 1, 24'hFFFFFF, 1, 52'hF_FFFFFF_FFFFFF, 1, 0);
    peek(0, v); chk("R9 source kept during transfer", v, 52'h1_010101_020202);
    peek(1, v); chk("R9 destination gets copy only", v, 52'h1_010101_020202);
    op(1, 0, 1, 0, 24'h800000, 1, 52'h2_ABCDEF_123456, 0, 0);
    peek(1, v); chk("R10 load beats bus write", v, 52'h2_ABCDEF_123456);
    peek(0, v); chk("R2 load leaves other bank", v, 52'h1_010101_020202);
  endtask

  task automatic t_both();
    logic [51:0] v;
    load(0, 52'h7_777777_777777);
    op(0, 0, 1, 1, 24'h400000, 0, 52'h0, 0, 0);
    peek(0, v); chk("R11 high wins over low", v, 52'h0_400000_000000);
  endtask

  initial begin
    rst = 1; mode16 = 0; bank_sel = 0; wr_data = 0; acc_in = 0; idle();
    repeat (3) @(negedge clk);
    rst = 0;
    begin
      logic [51:0] v;
      peek(0, v); chk("R1 initial bank0", v, 52'h0);
      peek(1, v); chk("R1 initial bank1", v, 52'h0);
    end
    t_hi24(); t_lo24(); t_hi16(); t_lo16(); t_xfer(); t_prio(); t_both(); t_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule